// File: doc/BRIEF.md
# Maintenance Interrupt and Port-Write Status Unit

This unit keeps the status, interrupt-enable and receive-mapping registers for a packet maintenance subsystem. It also drives one level-sensitive interrupt line. Other logic sends it single-cycle strobes:

- a port-write has arrived;
- the stored port-write payload has been read out;
- a port-write error has occurred;
- a maintenance read request or write request has been issued, each with a flag that says whether its address hit an enabled transmit translation window.

The unit decides whether each arriving port-write is stored or dropped. It latches these events into sticky status flags. Software clears a flag by writing a 1 to it.

Software uses a simple register port. A write strobe, address and data update a register. The read data follows the address combinationally. Each status flag is ANDed with its enable bit, and the results are ORed onto the interrupt line.

The unit also forms the 32-bit local bus address for a received maintenance packet. It does this from the programmed 8-bit receive base, the packet's configuration offset and its word address.

Top module: `mnt_irq_unit`

## Requirements
- R1: After reset, the status register (0x10080), the enable register (0x10084) and the mapping register (0x10088) all read 0, and `irq` is low.
- R2: Status bits are write-1-to-clear. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. Status bits 3, 2 and 31:7 always read 0.
- R3: If a port-write arrives while `pw_rx_en` is low, it is dropped: status bit 5 (dropped) is set and bit 4 (stored) is not set.
- R4: If a port-write arrives while the previous payload is still unread, it is dropped and status bit 5 is set.
- R5: If a port-write arrives while reception is enabled and no payload is pending, it is accepted. Status bit 4 (stored) is set and the payload becomes pending.
- R6: A read-out strobe clears the pending condition. If a read-out and an arrival occur in the same cycle, the read-out is taken first, so the arrival is accepted.
- R7: A write request with no window hit sets status bit 1. A read request with no window hit sets status bit 0. A request that hits a window sets nothing.
- R8: Enable register bits 6, 5, 4, 1 and 0 are read/write. All other enable bits read 0.
- R9: `irq` is high exactly when some status bit and its matching enable bit (same bit position) are both 1. It follows the registered state in the cycle after an event or write.
- R10: The mapping register keeps bits 31:24 as the receive base; its other bits read 0. `rx_local_addr` = {base[7:0], cfg_offset[20:0], word_addr, 2'b00}.
- R11: If a hardware set event and a write-1-to-clear hit the same status bit in the same cycle, the bit stays set.
- R12: A `pw_error` strobe sets status bit 6, which is sticky and write-1-to-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 20 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| pw_rx_en | input | 1 | Port-write reception enable |
| pw_arrive | input | 1 | Port-write arrival strobe |
| pw_readout | input | 1 | Payload read-out strobe |
| pw_error | input | 1 | Port-write error strobe |
| mreq_rd | input | 1 | Maintenance read request strobe |
| mreq_rd_hit | input | 1 | Read request address hit an enabled window |
| mreq_wr | input | 1 | Maintenance write request strobe |
| mreq_wr_hit | input | 1 | Write request address hit an enabled window |
| rx_cfg_offset | input | 21 | Configuration offset of the received maintenance packet |
| rx_word_addr | input | 1 | Word address of the received maintenance packet |
| rx_local_addr | output | 32 | Formed local bus address |
| irq | output | 1 | Interrupt output |

## Verification
The store-or-drop decision is driven with several input patterns:

- An arrival with reception disabled. This separates the enable-based drop from the pending-based drop.
- An accepted arrival followed by a second arrival. This shows the pending-based drop.
- A read-out followed by an arrival, which confirms the pending condition is cleared.
- A read-out and an arrival in the same cycle, which shows the read-out is ordered first.

Out-of-bounds strobes are sent both with and without a window hit. This shows that only misses latch a flag, and that read and write misses land on separate bits.

Write-1-to-clear is tested with three data patterns: a single one, all zeros and all ones. It is also tested in the same cycle as a set event.

The interrupt is checked with the matching enable bit set and with it cleared.

// File: rtl/mnt_irq_pkg.sv
package mnt_irq_pkg;
  localparam int STAT_W  = 7;
  localparam int BASE_W  = 8;
  localparam int OFS_W   = 21;
  localparam int WORD_W  = 1;
  localparam int LADDR_W = BASE_W + OFS_W + WORD_W + 2;

  // status / enable bit positions (decoded by software)
  localparam int B_RD_OOB  = 0;
  localparam int B_WR_OOB  = 1;
  localparam int B_STORED  = 4;
  localparam int B_DROPPED = 5;
  localparam int B_PW_ERR  = 6;

  // which bit positions hold real flops
  localparam logic [STAT_W-1:0] STAT_IMPL = 7'b111_0011;

  function automatic logic [LADDR_W-1:0] form_local_addr(
    input logic [BASE_W-1:0] base,
    input logic [OFS_W-1:0]  ofs,
    input logic [WORD_W-1:0] word
  );
    return {base, ofs, word, 2'b00};
  endfunction
endpackage

// File: rtl/mnt_pw_gate.sv
module mnt_pw_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic arrive,
  input  logic readout,
  output logic accept,
  output logic drop,
  output logic pending_q
);
  logic pending_eff;

  // a same-cycle read-out frees the slot before the arrival is judged
  assign pending_eff = pending_q & ~readout;
  assign accept      = arrive & rx_en & ~pending_eff;
  assign drop        = arrive & ~(rx_en & ~pending_eff);

  always_ff @(posedge clk) begin
    if (!rst_n)       pending_q <= 1'b0;
    else if (accept)  pending_q <= 1'b1;
    else if (readout) pending_q <= 1'b0;
  end
endmodule

// File: rtl/mnt_sticky_bank.sv
module mnt_sticky_bank #(
  parameter int          W    = 7,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_flop
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= 1'b0;
        else        q[i] <= set[i] | (q[i] & ~clr[i]);  // set wins
      end
    end else begin : g_tie
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/mnt_reg_port.sv
module mnt_reg_port
  import mnt_irq_pkg::*;
#(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 20'h10080,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 20'h10084,
  parameter logic [ADDR_W-1:0] MAP_ADDR  = 20'h10088
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [STAT_W-1:0] status,
  output logic [STAT_W-1:0] stat_clr,
  output logic [STAT_W-1:0] enable_q,
  output logic [BASE_W-1:0] base_q,
  output logic [31:0]       rdata
);
  localparam int PAD_W = 32 - STAT_W;
  localparam int LOW_W = 32 - BASE_W;

  logic hit_stat, hit_en, hit_map;
  logic unused_wdata;

  assign hit_stat     = (addr == STAT_ADDR);
  assign hit_en       = (addr == EN_ADDR);
  assign hit_map      = (addr == MAP_ADDR);
  assign unused_wdata = ^wdata[LOW_W-1:STAT_W];

  assign stat_clr = (wr && hit_stat) ? (wdata[STAT_W-1:0] & STAT_IMPL) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      base_q   <= '0;
    end else if (wr) begin
      if (hit_en)  enable_q <= wdata[STAT_W-1:0] & STAT_IMPL;
      if (hit_map) base_q   <= wdata[31:LOW_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_stat)     rdata = {{PAD_W{1'b0}}, status};
    else if (hit_en)  rdata = {{PAD_W{1'b0}}, enable_q};
    else if (hit_map) rdata = {base_q, {LOW_W{1'b0}}};
  end
endmodule

// File: rtl/mnt_irq_unit.sv
module mnt_irq_unit
  import mnt_irq_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 20'h10080,
  parameter logic [ADDR_W-1:0] EN_ADDR   = 20'h10084,
  parameter logic [ADDR_W-1:0] MAP_ADDR  = 20'h10088
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               pw_rx_en,
  input  logic               pw_arrive,
  input  logic               pw_readout,
  input  logic               pw_error,
  input  logic               mreq_rd,
  input  logic               mreq_rd_hit,
  input  logic               mreq_wr,
  input  logic               mreq_wr_hit,
  input  logic [OFS_W-1:0]   rx_cfg_offset,
  input  logic [WORD_W-1:0]  rx_word_addr,
  output logic [LADDR_W-1:0] rx_local_addr,
  output logic               irq
);
  // named internal events, visible to the bound checker
  logic              pw_accept, pw_drop, pw_pending;
  logic [STAT_W-1:0] set_vec, clr_vec, status_q, enable_q;
  logic [BASE_W-1:0] base_q;

  mnt_pw_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_en    (pw_rx_en),
    .arrive   (pw_arrive),
    .readout  (pw_readout),
    .accept   (pw_accept),
    .drop     (pw_drop),
    .pending_q(pw_pending)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[B_RD_OOB]  = mreq_rd & ~mreq_rd_hit;
    set_vec[B_WR_OOB]  = mreq_wr & ~mreq_wr_hit;
    set_vec[B_STORED]  = pw_accept;
    set_vec[B_DROPPED] = pw_drop;
    set_vec[B_PW_ERR]  = pw_error;
  end

  mnt_sticky_bank #(.W(STAT_W), .IMPL(STAT_IMPL)) u_stat (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (set_vec),
    .clr  (clr_vec),
    .q    (status_q)
  );

  mnt_reg_port #(
    .ADDR_W   (ADDR_W),
    .STAT_ADDR(STAT_ADDR),
    .EN_ADDR  (EN_ADDR),
    .MAP_ADDR (MAP_ADDR)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .status  (status_q),
    .stat_clr(clr_vec),
    .enable_q(enable_q),
    .base_q  (base_q),
    .rdata   (reg_rdata)
  );

  assign rx_local_addr = form_local_addr(base_q, rx_cfg_offset, rx_word_addr);
  assign irq           = |(status_q & enable_q);
endmodule

// File: rtl/mnt_irq_unit_chk.sv
module mnt_irq_unit_chk
  import mnt_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               pw_rx_en,
  input logic               pw_arrive,
  input logic               pw_readout,
  input logic               pw_accept,
  input logic               pw_pending,
  input logic               mreq_wr,
  input logic               mreq_wr_hit,
  input logic               mreq_rd,
  input logic               mreq_rd_hit,
  input logic               pw_error,
  input logic [STAT_W-1:0]  set_vec,
  input logic [STAT_W-1:0]  clr_vec,
  input logic [STAT_W-1:0]  status_q,
  input logic [STAT_W-1:0]  enable_q,
  input logic [BASE_W-1:0]  base_q,
  input logic [LADDR_W-1:0] rx_local_addr,
  input logic               irq
);
  AST_DROP_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    pw_arrive && !pw_rx_en |=> status_q[B_DROPPED]); // R3
  AST_DROP_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    pw_arrive && pw_pending && !pw_readout |=> status_q[B_DROPPED]); // R4
  AST_STORE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    pw_accept |=> pw_pending && status_q[B_STORED]); // R5
  AST_READOUT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    pw_readout && !pw_arrive |=> !pw_pending); // R6
  AST_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pw_readout && pw_arrive && pw_rx_en |=> status_q[B_STORED]); // R6
  AST_WR_OOB: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_wr && !mreq_wr_hit |=> status_q[B_WR_OOB]); // R7
  AST_RD_OOB: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_rd && !mreq_rd_hit |=> status_q[B_RD_OOB]); // R7
  AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    clr_vec[B_RD_OOB] && !set_vec[B_RD_OOB] |=> !status_q[B_RD_OOB]); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !status_q[2] && !status_q[3] && !enable_q[2] && !enable_q[3]); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_vec[B_PW_ERR] && clr_vec[B_PW_ERR] |=> status_q[B_PW_ERR]); // R11
  AST_PWERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pw_error |=> status_q[B_PW_ERR]); // R12
  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & enable_q) != '0 |-> irq); // R9
  AST_ADDR_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    rx_local_addr[1:0] == 2'b00 && rx_local_addr[31:24] == base_q); // R10
endmodule

bind mnt_irq_unit mnt_irq_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pw_rx_en     (pw_rx_en),
  .pw_arrive    (pw_arrive),
  .pw_readout   (pw_readout),
  .pw_accept    (pw_accept),
  .pw_pending   (pw_pending),
  .mreq_wr      (mreq_wr),
  .mreq_wr_hit  (mreq_wr_hit),
  .mreq_rd      (mreq_rd),
  .mreq_rd_hit  (mreq_rd_hit),
  .pw_error     (pw_error),
  .set_vec      (set_vec),
  .clr_vec      (clr_vec),
  .status_q     (status_q),
  .enable_q     (enable_q),
  .base_q       (base_q),
  .rx_local_addr(rx_local_addr),
  .irq          (irq)
);

// File: tb/mnt_irq_unit_tb.sv
module mnt_irq_unit_tb;
  localparam logic [19:0] A_STAT = 20'h10080;
  localparam logic [19:0] A_EN   = 20'h10084;
  localparam logic [19:0] A_MAP  = 20'h10088;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [19:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pw_rx_en = 1'b0, pw_arrive = 1'b0, pw_readout = 1'b0, pw_error = 1'b0;
  logic        mreq_rd = 1'b0, mreq_rd_hit = 1'b0, mreq_wr = 1'b0, mreq_wr_hit = 1'b0;
  logic [20:0] rx_cfg_offset = '0;
  logic [0:0]  rx_word_addr = '0;
  logic [31:0] rx_local_addr;
  logic        irq;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  mnt_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pw_rx_en(pw_rx_en),
    .pw_arrive(pw_arrive), .pw_readout(pw_readout), .pw_error(pw_error),
    .mreq_rd(mreq_rd), .mreq_rd_hit(mreq_rd_hit), .mreq_wr(mreq_wr),
    .mreq_wr_hit(mreq_wr_hit), .rx_cfg_offset(rx_cfg_offset),
    .rx_word_addr(rx_word_addr), .rx_local_addr(rx_local_addr), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [19:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [19:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_stat(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(A_STAT, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_EN, d);   chk("R1 enable", d, 0);
    rd(A_MAP, d);  chk("R1 map", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_oob;
    mreq_wr = 1; mreq_wr_hit = 1; mreq_rd = 1; mreq_rd_hit = 1;
    @(negedge clk);
    mreq_wr = 0; mreq_rd = 0; mreq_wr_hit = 0; mreq_rd_hit = 0;
    chk_stat("R7 hits set nothing", 32'h0);
    mreq_wr = 1; @(negedge clk); mreq_wr = 0;
    chk_stat("R7 write miss", 32'h2);
    mreq_rd = 1; @(negedge clk); mreq_rd = 0;
    chk_stat("R7 read miss", 32'h3);
    wr(A_STAT, 32'h1);
    chk_stat("R2 clear one", 32'h2);
    wr(A_STAT, 32'h0);
    chk_stat("R2 zero keeps", 32'h2);
    wr(A_STAT, 32'hFFFF_FFFF);
    chk_stat("R2 clear all", 32'h0);
  endtask

  task automatic t_pw;
    pw_rx_en = 0; pw_arrive = 1; @(negedge clk); pw_arrive = 0;
    chk_stat("R3 drop disabled", 32'h20);
    wr(A_STAT, 32'h30);
    pw_rx_en = 1; pw_arrive = 1; @(negedge clk); pw_arrive = 0;
    chk_stat("R5 accepted", 32'h10);
    pw_arrive = 1; @(negedge clk); pw_arrive = 0;
    chk_stat("R4 drop pending", 32'h30);
    wr(A_STAT, 32'h30);
    pw_readout = 1; @(negedge clk); pw_readout = 0;
    pw_arrive = 1; @(negedge clk); pw_arrive = 0;
    chk_stat("R6 readout frees", 32'h10);
    wr(A_STAT, 32'h30);
    pw_arrive = 1; pw_readout = 1; @(negedge clk); pw_arrive = 0; pw_readout = 0;
    chk_stat("R6 same cycle accepted", 32'h10);
    pw_arrive = 1; @(negedge clk); pw_arrive = 0;
    chk_stat("R6 pending after same cycle", 32'h30);
    pw_readout = 1; @(negedge clk); pw_readout = 0;
    wr(A_STAT, 32'h30);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, d); chk("R8 enable mask", d, 32'h73);
    chk("R9 irq no status", {31'b0, irq}, 0);
    pw_error = 1; @(negedge clk); pw_error = 0;
    chk_stat("R12 pw error", 32'h40);
    chk("R9 irq raised", {31'b0, irq}, 1);
    wr(A_EN, 32'h0000_0033);
    rd(A_EN, d); chk("R8 enable write", d, 32'h33);
    chk("R9 irq masked", {31'b0, irq}, 0);
    pw_error = 1; wr(A_STAT, 32'h40); pw_error = 0;
    chk_stat("R11 set wins", 32'h40);
    wr(A_STAT, 32'h40);
    chk_stat("R12 w1c", 32'h0);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d, exp;
    wr(A_MAP, 32'hABFF_FFFF);
    rd(A_MAP, d); chk("R10 map read", d, 32'hAB00_0000);
    rx_cfg_offset = 21'h12345; rx_word_addr = 1'b1; #1;
    exp = (32'hAB << 24) | (32'h12345 << 3) | (32'd1 << 2);
    chk("R10 address", rx_local_addr, exp);
    rx_cfg_offset = 21'h1FFFFF; rx_word_addr = 1'b0; #1;
    exp = (32'hAB << 24) | (32'h1FFFFF << 3);
    chk("R10 address max offset", rx_local_addr, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_oob();
    t_pw();
    t_irq();
    t_map();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule